// File: doc/BRIEF.md
# Sixteen-Pin LED Mode Selector with Two Shared Blink Generators

This block drives sixteen open-drain LED pins. Each pin has a 2-bit mode field, and the field picks one of four behaviours for that pin. The pin can be released to high impedance (LED dark) or pulled low all the time (LED lit). It can also blink from either of two blink generators, which every pin shares. Each generator has two 8-bit registers. The prescale register sets how many base-enable pulses make one phase step, and the duty register sets for how many of the 256 phase steps the pin is pulled low. A pin is modelled as one bit of `led_oe`, and a 1 on that bit means the pin is pulled low.

Software loads the registers through a plain single-cycle register port with address, write data, write strobe and combinational read data. Two read-only addresses return the live levels on the pins. The base enable comes from outside as a one-cycle pulse at whatever rate the system picks. That is the only timing source of the generators. The serial bus that would sit in front of this port, the current switches and the pads belong to the surrounding design.

Top module: `led_mode_sel`

## Requirements
- R1: After reset, every mode field is 00, both prescale registers read 0x00, both duty registers read 0x80, and `led_oe` is all zero.
- R2: A pin whose mode field is 00 has its `led_oe` bit at 0.
- R3: A pin whose mode field is 01 has its `led_oe` bit at 1.
- R4: A pin whose mode field is 10 follows the active output of generator 0, and a pin whose field is 11 follows the active output of generator 1.
- R5: Mode registers sit at addresses 0x06, 0x07, 0x08 and 0x09. The register at 0x06+k holds bits [2j+1:2j], which control pin 4k+j, for j from 0 to 3.
- R6: Each generator keeps a prescale count that starts at 0. On a cycle with `base_en` high, a count that is at or above its prescale value (the value held before that edge) resets to 0 and advances the 8-bit phase by one, wrapping 255 to 0. Otherwise the count increments. The phase changes at no other time, so a step comes every PSC+1 enables.
- R7: A generator is active while its phase is below its duty value. Duty 0x00 is never active, and duty 0xFF is active on every phase except 255.
- R8: Address 0x02 is prescale 0, 0x03 is duty 0, 0x04 is prescale 1 and 0x05 is duty 1. Every writable register reads back the last value written.
- R9: Reading 0x00 returns `pin_in[7:0]`, and reading 0x01 returns `pin_in[15:8]`.
- R10: Writes to 0x00, 0x01 and any address above 0x09 change no register. Reads of addresses above 0x09 return 0x00.
- R11: A register write is visible on `led_oe` and `reg_rdata` right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_en | input | 1 | Base enable pulse that drives both prescalers |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Sampled levels of the sixteen pins |
| led_oe | output | 16 | Per-pin pull-low enable; 1 = pin driven low |

## Verification
A register write and a prescaler wrap can land on the same clock edge. If that write goes to the prescale or duty register of the generator that is stepping, the step must use the old prescale value, and the duty compare must use the new duty value. The bench provokes this on purpose. It holds `base_en` high while it rewrites a prescale register that is far above the current count, or far below it, and it rewrites duty registers while pins are blinking. A behavioural model updates its counters with the pre-write values before it applies the write. On every cycle the bench compares `led_oe` and the read data with that model.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ON   = 2'b01,
    MODE_GEN0 = 2'b10,
    MODE_GEN1 = 2'b11
  } led_mode_e;

  localparam int unsigned MODE_W     = 2;
  localparam int unsigned N_GEN      = 2;
  localparam int unsigned A_PIN_BASE = 0;
  localparam int unsigned A_PSC0     = 2;
  localparam int unsigned A_DUTY0    = 3;
  localparam int unsigned A_PSC1     = 4;
  localparam int unsigned A_DUTY1    = 5;
  localparam int unsigned A_SEL_BASE = 6;
  localparam logic [7:0]  DUTY_RESET = 8'h80;

endpackage

// File: rtl/led_regfile.sv
module led_regfile
  import led_sel_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [REG_W-1:0]                     wdata,
  input  logic [N_PINS-1:0]                    pin_in,
  output logic [REG_W-1:0]                     rdata,
  output logic [N_PINS*MODE_W-1:0]             sel_flat,
  output logic [N_GEN-1:0][REG_W-1:0]          psc,
  output logic [N_GEN-1:0][REG_W-1:0]          duty
);

  localparam int unsigned N_SEL = (N_PINS * MODE_W) / REG_W;
  localparam int unsigned N_IN  = N_PINS / REG_W;

  logic [N_SEL-1:0][REG_W-1:0] sel_q;
  logic [N_GEN-1:0][REG_W-1:0] psc_q;
  logic [N_GEN-1:0][REG_W-1:0] duty_q;

  // Address of the prescale / duty register of generator g
  function automatic logic [ADDR_W-1:0] psc_addr(input int unsigned g);
    return ADDR_W'(A_PSC0 + 2 * g);
  endfunction

  function automatic logic [ADDR_W-1:0] duty_addr(input int unsigned g);
    return ADDR_W'(A_DUTY0 + 2 * g);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      psc_q  <= '0;
      for (int g = 0; g < N_GEN; g++) duty_q[g] <= REG_W'(DUTY_RESET);
    end else if (we) begin
      for (int g = 0; g < N_GEN; g++) begin
        if (addr == psc_addr(g))  psc_q[g]  <= wdata;
        if (addr == duty_addr(g)) duty_q[g] <= wdata;
      end
      for (int k = 0; k < N_SEL; k++) begin
        if (addr == ADDR_W'(A_SEL_BASE + k)) sel_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (addr == ADDR_W'(A_PIN_BASE + k)) rdata = pin_in[k*REG_W +: REG_W];
    end
    for (int g = 0; g < N_GEN; g++) begin
      if (addr == psc_addr(g))  rdata = psc_q[g];
      if (addr == duty_addr(g)) rdata = duty_q[g];
    end
    for (int k = 0; k < N_SEL; k++) begin
      if (addr == ADDR_W'(A_SEL_BASE + k)) rdata = sel_q[k];
    end
  end

  assign sel_flat = sel_q;
  assign psc      = psc_q;
  assign duty     = duty_q;

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en,
  input  logic [CNT_W-1:0] psc,
  input  logic [CNT_W-1:0] duty,
  output logic             tick,
  output logic [CNT_W-1:0] phase,
  output logic             active
);

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] phase_q;

  // wrap on >= so a lowered prescale value takes hold without a long stall
  assign tick = base_en && (pre_q >= psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      phase_q <= '0;
    end else if (base_en) begin
      if (tick) begin
        pre_q   <= '0;
        phase_q <= phase_q + CNT_W'(1);
      end else begin
        pre_q   <= pre_q + CNT_W'(1);
      end
    end
  end

  assign phase  = phase_q;
  assign active = (phase_q < duty);

endmodule

// File: rtl/led_out_mux.sv
module led_out_mux
  import led_sel_pkg::*;
#(
  parameter int unsigned N_PINS = 16
) (
  input  logic [N_PINS*MODE_W-1:0] sel_flat,
  input  logic [N_GEN-1:0]         gen_act,
  output logic [N_PINS-1:0]        oe
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    led_mode_e mode;
    assign mode = led_mode_e'(sel_flat[i*MODE_W +: MODE_W]);
    always_comb begin
      unique case (mode)
        MODE_OFF:  oe[i] = 1'b0;
        MODE_ON:   oe[i] = 1'b1;
        MODE_GEN0: oe[i] = gen_act[0];
        MODE_GEN1: oe[i] = gen_act[1];
        default:   oe[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/led_mode_sel.sv
module led_mode_sel
  import led_sel_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] led_oe
);

  logic [N_PINS*MODE_W-1:0]     sel_flat;
  logic [N_GEN-1:0][REG_W-1:0]  psc_q;
  logic [N_GEN-1:0][REG_W-1:0]  duty_q;
  logic [N_GEN-1:0][REG_W-1:0]  phase;
  logic [N_GEN-1:0]             tick;
  logic [N_GEN-1:0]             act;

  led_regfile #(
    .N_PINS (N_PINS),
    .REG_W  (REG_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .pin_in   (pin_in),
    .rdata    (reg_rdata),
    .sel_flat (sel_flat),
    .psc      (psc_q),
    .duty     (duty_q)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    led_blink_gen #(.CNT_W(REG_W)) u_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_en (base_en),
      .psc     (psc_q[g]),
      .duty    (duty_q[g]),
      .tick    (tick[g]),
      .phase   (phase[g]),
      .active  (act[g])
    );
  end

  led_out_mux #(.N_PINS(N_PINS)) u_mux (
    .sel_flat (sel_flat),
    .gen_act  (act),
    .oe       (led_oe)
  );

endmodule

// File: rtl/led_sel_chk.sv
module led_sel_chk
  import led_sel_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        base_en,
  input logic                        reg_we,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [REG_W-1:0]            reg_wdata,
  input logic [N_PINS*MODE_W-1:0]    sel_flat,
  input logic [N_GEN-1:0][REG_W-1:0] psc_q,
  input logic [N_GEN-1:0][REG_W-1:0] duty_q,
  input logic [N_GEN-1:0][REG_W-1:0] phase,
  input logic [N_GEN-1:0]            tick,
  input logic [N_GEN-1:0]            act,
  input logic [N_PINS-1:0]           led_oe
);

  localparam int unsigned FIELDS = REG_W / MODE_W;
  localparam int unsigned N_SEL  = N_PINS / FIELDS;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    localparam int unsigned K = i / FIELDS;
    localparam int unsigned J = i % FIELDS;

    // R2 and R5: writing field 00 releases that pin on the next cycle
    p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_SEL_BASE + K) &&
       reg_wdata[J*MODE_W +: MODE_W] == 2'b00) |=> !led_oe[i]);

    // R3 and R11: writing field 01 pulls that pin low on the next cycle
    p_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_SEL_BASE + K) &&
       reg_wdata[J*MODE_W +: MODE_W] == 2'b01) |=> led_oe[i]);
  end

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[g] |=> $stable(phase[g]));

    p_tick_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |-> base_en);

    p_duty0_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q[g] == '0) |-> !act[g]);
  end

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr < ADDR_W'(A_PSC0) ||
                reg_addr >= ADDR_W'(A_SEL_BASE + N_SEL)))
    |=> ($stable(sel_flat) && $stable(psc_q) && $stable(duty_q)));

endmodule

bind led_mode_sel led_sel_chk #(
  .N_PINS (N_PINS),
  .REG_W  (REG_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_en   (base_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sel_flat  (sel_flat),
  .psc_q     (psc_q),
  .duty_q    (duty_q),
  .phase     (phase),
  .tick      (tick),
  .act       (act),
  .led_oe    (led_oe)
);

// File: tb/tb_led_mode_sel.sv
`timescale 1ns/1ps
module tb_led_mode_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] led_oe;

  always #2.5 clk = ~clk;

  led_mode_sel dut (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .led_oe(led_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_sel [16];
  int m_psc [2];
  int m_duty[2];
  int m_pre [2];
  int m_ph  [2];

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) m_sel[i] = 0;
    for (int g = 0; g < 2; g++) begin
      m_psc[g] = 0; m_duty[g] = 128; m_pre[g] = 0; m_ph[g] = 0;
    end
  endfunction

  function automatic void model_step(input bit we, input int a, input int d, input bit en);
    // counters first, with the register values from before this edge
    for (int g = 0; g < 2; g++) begin
      if (en) begin
        if (m_pre[g] >= m_psc[g]) begin
          m_pre[g] = 0;
          m_ph[g]  = (m_ph[g] + 1) % 256;
        end else begin
          m_pre[g] = m_pre[g] + 1;
        end
      end
    end
    if (we) begin
      if (a == 2) m_psc[0]  = d;
      if (a == 3) m_duty[0] = d;
      if (a == 4) m_psc[1]  = d;
      if (a == 5) m_duty[1] = d;
      if (a >= 6 && a <= 9)
        for (int j = 0; j < 4; j++) m_sel[(a-6)*4 + j] = (d >> (2*j)) & 3;
    end
  endfunction

  function automatic logic [15:0] exp_oe();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      case (m_sel[i])
        0: v[i] = 1'b0;
        1: v[i] = 1'b1;
        2: v[i] = (m_ph[0] < m_duty[0]);
        default: v[i] = (m_ph[1] < m_duty[1]);
      endcase
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    int v;
    v = 0;
    case (a)
      0: v = pin_in[7:0];
      1: v = pin_in[15:8];
      2: v = m_psc[0];
      3: v = m_duty[0];
      4: v = m_psc[1];
      5: v = m_duty[1];
      6, 7, 8, 9:
        for (int j = 0; j < 4; j++) v = v | (m_sel[(a-6)*4 + j] << (2*j));
      default: v = 0;
    endcase
    return 8'(v);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " led_oe"}, led_oe, exp_oe());
    check({tag, " rdata"}, {8'h00, reg_rdata}, {8'h00, exp_rd(int'(reg_addr))});
  endtask

  task automatic cyc(input bit we, input int a, input int d, input bit en, input string tag);
    @(negedge clk);
    reg_we = we; reg_addr = 8'(a); reg_wdata = 8'(d); base_en = en;
    @(posedge clk);
    #1;
    model_step(we, a, d, en);
    compare(tag);
  endtask

  // idle cycles reading around the map, with a chosen enable rhythm
  task automatic run(input int n, input int en_mod, input string tag);
    for (int c = 0; c < n; c++)
      cyc(1'b0, c % 12, 0, (c % en_mod) != 0 || en_mod == 1, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset led_oe", led_oe, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values read back through the port
    for (int a = 2; a <= 9; a++) cyc(1'b0, a, 0, 1'b0, "R1");

    // R9: pin levels on the two read-only addresses
    @(negedge clk); pin_in = 16'hA55A;
    cyc(1'b0, 0, 0, 1'b0, "R9");
    cyc(1'b0, 1, 0, 1'b0, "R9");
    @(negedge clk); pin_in = 16'h3CC3;
    cyc(1'b0, 0, 0, 1'b0, "R9");
    cyc(1'b0, 1, 0, 1'b0, "R9");

    // R3, R5, R11: single fields switched on in each mode register
    cyc(1'b1, 6, 8'b01_00_00_01, 1'b0, "R5 R11");
    cyc(1'b1, 7, 8'b00_01_00_00, 1'b0, "R5");
    cyc(1'b1, 8, 8'b00_00_01_00, 1'b0, "R5");
    cyc(1'b1, 9, 8'b01_01_01_01, 1'b0, "R3");
    // R2: release again
    cyc(1'b1, 9, 8'b00_00_00_00, 1'b0, "R2");
    cyc(1'b1, 6, 8'b00_00_00_01, 1'b0, "R2");

    // R8: generator registers read back
    cyc(1'b1, 2, 3, 1'b0, "R8");
    cyc(1'b1, 3, 8'h40, 1'b0, "R8");
    cyc(1'b1, 4, 1, 1'b0, "R8");
    cyc(1'b1, 5, 8'hC0, 1'b0, "R8");
    for (int a = 2; a <= 5; a++) cyc(1'b0, a, 0, 1'b0, "R8");

    // R4, R6, R7: both generators blinking under two enable rhythms
    cyc(1'b1, 6, 8'b10_10_11_11, 1'b0, "R4");
    cyc(1'b1, 7, 8'b11_10_01_00, 1'b0, "R4");
    cyc(1'b1, 8, 8'hAA, 1'b0, "R4");
    cyc(1'b1, 9, 8'hFF, 1'b0, "R4");
    run(1500, 3, "R4 R6");
    run(800, 1, "R4 R6");

    // R7: duty extremes, fast prescale
    cyc(1'b1, 2, 0, 1'b1, "R7");
    cyc(1'b1, 3, 0, 1'b1, "R7 duty0");
    run(600, 1, "R7 duty0");
    cyc(1'b1, 3, 8'hFF, 1'b1, "R7 duty255");
    run(600, 1, "R7 duty255");

    // R10: writes to read-only and unused addresses
    cyc(1'b1, 0, 8'h5A, 1'b1, "R10");
    cyc(1'b1, 1, 8'hA5, 1'b1, "R10");
    cyc(1'b1, 10, 8'h77, 1'b1, "R10");
    cyc(1'b1, 255, 8'h33, 1'b1, "R10");
    for (int a = 0; a <= 11; a++) cyc(1'b0, a, 0, 1'b0, "R10");
    cyc(1'b0, 200, 0, 1'b0, "R10 unused read");

    // R6: prescale rewrite on an enabled cycle, first raised then lowered
    cyc(1'b1, 2, 200, 1'b1, "R6 raise");
    cyc(1'b1, 3, 8'h80, 1'b1, "R6");
    run(120, 1, "R6");
    cyc(1'b1, 2, 2, 1'b1, "R6 lower collide");
    run(300, 2, "R6");
    // duty rewrite while blinking, with enable high
    for (int k = 0; k < 20; k++) begin
      cyc(1'b1, 5, (k * 37) % 256, 1'b1, "R7 duty rewrite");
      run(15, 1, "R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule